// File: doc/BRIEF.md
# Poison-Marking Execute Stage with Pipelined Multiplier

This block is the execute step of an in-order pipeline, followed by a small memory step. Each instruction that arrives carries a one-bit epoch tag. The stage compares that tag with its own current epoch. If the two differ, the instruction belongs to a path that has been abandoned. It is then not executed. It still travels downstream with a poisoned flag, so that later stages can do their scoreboard bookkeeping. They make no architectural change for it.

Instructions on the live path are handled in one of two ways. Single-cycle operations (arithmetic, logic, address generation and compare-branch) finish in the cycle they are presented. Multiplies go to a three-stage pipelined unit. While the multiply is in flight the controller sits in its waiting state. ALU results are driven onto a bypass port in the cycle they finish. A taken branch on the live path raises a redirect with its target and flips the epoch. The memory step issues a data-memory request only for live loads and stores. Every other entry passes through unchanged, and a stalled consumer holds the final result in place.

The controller has two states. ST_RUN accepts and issues work. ST_WAIT holds the instruction at the input while the multiplier works. Its transitions are:

- ISSUE: from ST_RUN to ST_WAIT, on a live multiply.
- RETIRE: from ST_WAIT to ST_RUN, when the multiplier answers and the output register can take the result.
- Every other cycle holds the current state.

Top module: `exec_poison_stage`

## Requirements
- R1: An instruction whose in_epoch differs from cur_epoch is consumed (in_ready high) as soon as the output register can take it. It appears at the write-back port with wb_poison=1, the same op and rd, wb_wen set as for the live op, and wb_data=0. It causes no bypass, no redirect and no memory request.
- R2: Live single-cycle ops are encoded on in_op as follows, each consumed in the cycle it is presented when the output register is free:
  - 0: a+b
  - 1: a-b
  - 2: a&b
  - 3: a^b
  - wb_wen=1 for all four.
- R3: bypass_valid is high, with bypass_rd and bypass_data equal to the destination and result, only in the cycle a live op 0..3 is consumed. It stays low for multiplies, loads, stores, branches and poisoned entries.
- R4: A live multiply (op 4) returns the low 32 bits of a*b, with wb_wen=1. With an unstalled consumer, in_ready rises at the third falling edge after the multiply is presented.
- R5: In ST_WAIT, in_ready stays low until the multiplier's answer can be retired; no new instruction is accepted.
- R6: A live compare-branch (op 7) with a==b raises redir_valid with redir_target=imm in its consume cycle, and cur_epoch toggles at that clock edge. With a!=b there is no redirect and no toggle. Both cases give wb_wen=0 and wb_data=0.
- R7: Loads (op 5) and stores (op 6) use address a+imm. A live one raises exactly one memory request (mem_we=1 only for stores, mem_wdata=b). A load's wb_data is mem_rdata from that request cycle with wb_wen=1. A store's wb_data is b with wb_wen=0.
- R8: Results leave in program order. While wb_valid is high and wb_ready low, wb_valid, wb_data and wb_rd hold their values.
- R9: After reset, cur_epoch=0, wb_valid=0, in_ready=0, bypass_valid=0, redir_valid=0 and mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | Instruction consumed this cycle |
| in_epoch | input | 1 | Epoch tag of the instruction |
| in_op | input | 3 | Operation code (see R2, R4, R6, R7) |
| in_rd | input | 5 | Destination register index |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_imm | input | 32 | Offset or branch target |
| cur_epoch | output | 1 | Current epoch |
| bypass_valid | output | 1 | ALU result forwarded this cycle |
| bypass_rd | output | 5 | Forwarded destination |
| bypass_data | output | 32 | Forwarded value |
| redir_valid | output | 1 | Taken live branch |
| redir_target | output | 32 | Redirect address |
| mem_req_valid | output | 1 | Data-memory access this cycle |
| mem_we | output | 1 | Access is a store |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, same cycle as the request |
| wb_valid | output | 1 | Result available |
| wb_ready | input | 1 | Consumer accepts result |
| wb_poison | output | 1 | Result is from a killed instruction |
| wb_op | output | 3 | Operation code of the result |
| wb_rd | output | 5 | Destination register index |
| wb_wen | output | 1 | Op writes a register |
| wb_data | output | 32 | Result value |

## Verification
Each result has a known cycle:

- Bypass and redirect are combinational in the consume cycle, so the bench checks them just before that rising edge.
- The new epoch is sampled one time step after that edge.
- A single-cycle result passes the output register and the memory register before it reaches the write-back port. Its first valid falling-edge sample is therefore two edges after it is consumed.
- A multiply is consumed three falling edges after it is presented, and its result follows after those two extra edges.

The bench samples only at falling edges and drives on them, so no check depends on the order of processes at a rising edge.

// File: rtl/exec_pkg.sv
package exec_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_XOR = 3'd3,
        OP_MUL = 3'd4,
        OP_LD  = 3'd5,
        OP_ST  = 3'd6,
        OP_BEQ = 3'd7
    } op_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WAIT = 1'b1
    } ctl_t;

    function automatic logic is_alu(op_t op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_XOR);
    endfunction

    function automatic logic writes_reg(op_t op);
        return is_alu(op) || (op == OP_MUL) || (op == OP_LD);
    endfunction
endpackage

// File: rtl/ex_alu.sv
module ex_alu
    import exec_pkg::*;
#(
    parameter int W = 32
) (
    input  op_t          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] imm,
    output logic [W-1:0] data,
    output logic [W-1:0] addr,
    output logic         taken
);
    always_comb begin
        data  = '0;
        addr  = a + imm;
        taken = 1'b0;
        unique case (op)
            OP_ADD: data = a + b;
            OP_SUB: data = a - b;
            OP_AND: data = a & b;
            OP_XOR: data = a ^ b;
            OP_ST:  data = b;
            OP_BEQ: begin
                addr  = imm;
                taken = (a == b);
            end
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/ex_mul3.sv
module ex_mul3 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         take,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int HALF = W / 2;

    logic         s1_v, s2_v, s3_v;
    logic [W-1:0] s1_lo, s1_b, s2_lo, s2_cross, s3_sum;
    logic [HALF-1:0] s1_ahi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            s3_v <= 1'b0;
        end else begin
            s1_v <= req;
            s2_v <= s1_v;
            if (s2_v)      s3_v <= 1'b1;
            else if (take) s3_v <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (req) begin
            s1_lo  <= {{HALF{1'b0}}, a[HALF-1:0]} * b;
            s1_ahi <= a[W-1:HALF];
            s1_b   <= b;
        end
        if (s1_v) begin
            s2_lo    <= s1_lo;
            s2_cross <= ({{HALF{1'b0}}, s1_ahi} * {{HALF{1'b0}}, s1_b[HALF-1:0]}) << HALF;
        end
        if (s2_v) begin
            s3_sum <= s2_lo + s2_cross;
        end
    end

    assign done   = s3_v;
    assign result = s3_sum;
endmodule

// File: rtl/ex_mem_stage.sv
module ex_mem_stage
    import exec_pkg::*;
#(
    parameter int W  = 32,
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          x_valid,
    input  logic          x_poison,
    input  op_t           x_op,
    input  logic [RW-1:0] x_rd,
    input  logic          x_wen,
    input  logic [W-1:0]  x_data,
    input  logic [W-1:0]  x_addr,
    output logic          x_take,
    output logic          mem_req_valid,
    output logic          mem_we,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata,
    output logic          wb_valid,
    input  logic          wb_ready,
    output logic          wb_poison,
    output op_t           wb_op,
    output logic [RW-1:0] wb_rd,
    output logic          wb_wen,
    output logic [W-1:0]  wb_data
);
    logic is_mem;

    assign x_take        = !wb_valid || wb_ready;
    assign is_mem        = (x_op == OP_LD) || (x_op == OP_ST);
    assign mem_req_valid = x_valid && x_take && !x_poison && is_mem;
    assign mem_we        = (x_op == OP_ST);
    assign mem_addr      = x_addr;
    assign mem_wdata     = x_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
        end else if (x_take) begin
            wb_valid <= x_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (x_take && x_valid) begin
            wb_poison <= x_poison;
            wb_op     <= x_op;
            wb_rd     <= x_rd;
            wb_wen    <= x_wen;
            wb_data   <= (!x_poison && x_op == OP_LD) ? mem_rdata : x_data;
        end
    end
endmodule

// File: rtl/exec_poison_stage.sv
module exec_poison_stage
    import exec_pkg::*;
#(
    parameter int W  = 32,
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_epoch,
    input  logic [2:0]    in_op,
    input  logic [RW-1:0] in_rd,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    input  logic [W-1:0]  in_imm,
    output logic          cur_epoch,
    output logic          bypass_valid,
    output logic [RW-1:0] bypass_rd,
    output logic [W-1:0]  bypass_data,
    output logic          redir_valid,
    output logic [W-1:0]  redir_target,
    output logic          mem_req_valid,
    output logic          mem_we,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata,
    output logic          wb_valid,
    input  logic          wb_ready,
    output logic          wb_poison,
    output logic [2:0]    wb_op,
    output logic [RW-1:0] wb_rd,
    output logic          wb_wen,
    output logic [W-1:0]  wb_data
);
    ctl_t          st_q, st_d;
    op_t           op;
    logic          live, fire, mul_req, mul_take, mul_done, can_enq, x_take, taken;
    logic [W-1:0]  alu_data, alu_addr, mul_data;
    logic          waiting;

    logic          xr_valid, xr_poison, xr_wen, n_poison, n_wen;
    op_t           xr_op, wb_op_e;
    logic [RW-1:0] xr_rd;
    logic [W-1:0]  xr_data, xr_addr, n_data, n_addr;

    assign op      = op_t'(in_op);
    assign live    = (in_epoch == cur_epoch);
    assign can_enq = !xr_valid || x_take;
    assign waiting = (st_q == ST_WAIT);

    ex_alu #(.W(W)) u_alu (
        .op(op), .a(in_a), .b(in_b), .imm(in_imm),
        .data(alu_data), .addr(alu_addr), .taken(taken)
    );

    ex_mul3 #(.W(W)) u_mul (
        .clk(clk), .rst_n(rst_n), .req(mul_req), .a(in_a), .b(in_b),
        .take(mul_take), .done(mul_done), .result(mul_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // next state and issue decisions
    always_comb begin
        st_d     = st_q;
        fire     = 1'b0;
        mul_req  = 1'b0;
        mul_take = 1'b0;
        n_poison = !live;
        n_wen    = writes_reg(op);
        n_data   = '0;
        n_addr   = '0;
        unique case (st_q)
            ST_RUN: begin
                if (in_valid) begin
                    if (!live) begin
                        fire = can_enq;
                    end else if (op == OP_MUL) begin
                        mul_req = 1'b1;
                        st_d    = ST_WAIT;
                    end else begin
                        fire   = can_enq;
                        n_data = alu_data;
                        n_addr = alu_addr;
                    end
                end
            end
            ST_WAIT: begin
                n_poison = 1'b0;
                if (mul_done && can_enq) begin
                    fire     = 1'b1;
                    mul_take = 1'b1;
                    n_data   = mul_data;
                    st_d     = ST_RUN;
                end
            end
        endcase
    end

    // outputs of the stage
    always_comb begin
        in_ready     = fire;
        bypass_valid = fire && !waiting && live && is_alu(op);
        bypass_rd    = in_rd;
        bypass_data  = alu_data;
        redir_valid  = fire && !waiting && live && (op == OP_BEQ) && taken;
        redir_target = alu_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           cur_epoch <= 1'b0;
        else if (redir_valid) cur_epoch <= ~cur_epoch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      xr_valid <= 1'b0;
        else if (fire)   xr_valid <= 1'b1;
        else if (x_take) xr_valid <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (fire) begin
            xr_poison <= n_poison;
            xr_op     <= op;
            xr_rd     <= in_rd;
            xr_wen    <= n_wen;
            xr_data   <= n_data;
            xr_addr   <= n_addr;
        end
    end

    ex_mem_stage #(.W(W), .RW(RW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .x_valid(xr_valid), .x_poison(xr_poison), .x_op(xr_op), .x_rd(xr_rd),
        .x_wen(xr_wen), .x_data(xr_data), .x_addr(xr_addr), .x_take(x_take),
        .mem_req_valid(mem_req_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_poison(wb_poison),
        .wb_op(wb_op_e), .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_data(wb_data)
    );

    assign wb_op = wb_op_e;
endmodule

// File: rtl/exec_poison_checker.sv
module exec_poison_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_ready,
    input logic         in_epoch,
    input logic [2:0]   in_op,
    input logic         cur_epoch,
    input logic         bypass_valid,
    input logic         redir_valid,
    input logic         mem_req_valid,
    input logic         wb_valid,
    input logic         wb_ready,
    input logic [W-1:0] wb_data,
    input logic [4:0]   wb_rd,
    input logic         waiting,
    input logic         mul_done
);
    p_bypass_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_valid |-> (in_ready && in_epoch == cur_epoch && !in_op[2]));

    p_wait_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !mul_done) |-> !in_ready);

    p_redir_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (in_ready && in_op == 3'd7 && in_epoch == cur_epoch));

    p_epoch_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> (cur_epoch != $past(cur_epoch)));

    p_memreq_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> wb_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data) && $stable(wb_rd)));
endmodule

bind exec_poison_stage exec_poison_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .in_epoch(in_epoch),
    .in_op(in_op), .cur_epoch(cur_epoch), .bypass_valid(bypass_valid),
    .redir_valid(redir_valid), .mem_req_valid(mem_req_valid),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .wb_rd(wb_rd), .waiting(waiting), .mul_done(mul_done)
);

// File: tb/exec_poison_stage_test.sv
`timescale 1ns/1ps
module exec_poison_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_epoch = 1'b0;
    logic [2:0]  in_op = '0;
    logic [4:0]  in_rd = '0;
    logic [31:0] in_a = '0, in_b = '0, in_imm = '0;
    logic        in_ready, cur_epoch, bypass_valid, redir_valid;
    logic [4:0]  bypass_rd, wb_rd;
    logic [31:0] bypass_data, redir_target, mem_addr, mem_wdata, mem_rdata, wb_data;
    logic        mem_req_valid, mem_we, wb_valid, wb_poison, wb_wen;
    logic        wb_ready = 1'b1;
    logic [2:0]  wb_op;

    always #2.5 clk = ~clk;
    assign mem_rdata = mem_addr ^ 32'hA5A5_0000;

    exec_poison_stage uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_epoch(in_epoch), .in_op(in_op), .in_rd(in_rd), .in_a(in_a),
        .in_b(in_b), .in_imm(in_imm), .cur_epoch(cur_epoch),
        .bypass_valid(bypass_valid), .bypass_rd(bypass_rd), .bypass_data(bypass_data),
        .redir_valid(redir_valid), .redir_target(redir_target),
        .mem_req_valid(mem_req_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_poison(wb_poison),
        .wb_op(wb_op), .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_data(wb_data)
    );

    typedef struct packed {
        logic        poison;
        logic [2:0]  op;
        logic [4:0]  rd;
        logic        wen;
        logic [31:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0, errors = 0, cyc = 0;
    int   mem_seen = 0, mem_exp = 0;
    logic m_epoch = 1'b0, stall_on = 1'b0, done = 1'b0;
    logic hold_pend = 1'b0;
    logic [31:0] hold_data = '0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // driver: presents one instruction, checks same-cycle outputs, pushes expectation
    task automatic send(input logic [2:0] op, input logic ep, input logic [4:0] rd,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] imm);
        logic  poison, e_byp, e_redir, e_mem;
        int    waits;
        exp_t  e;
        poison  = (ep != m_epoch);
        e_byp   = !poison && (op < 3'd4);
        e_redir = !poison && (op == 3'd7) && (a == b);
        e_mem   = !poison && (op == 3'd5 || op == 3'd6);
        e.poison = poison;
        e.op     = op;
        e.rd     = rd;
        e.wen    = (op < 3'd6) && (op != 3'd6);
        e.data   = '0;
        if (!poison) begin
            case (op)
                3'd0: e.data = a + b;
                3'd1: e.data = a - b;
                3'd2: e.data = a & b;
                3'd3: e.data = a ^ b;
                3'd4: e.data = a * b;
                3'd5: e.data = (a + imm) ^ 32'hA5A5_0000;
                3'd6: e.data = b;
                default: e.data = '0;
            endcase
        end
        if (e_mem) mem_exp++;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_epoch = ep; in_rd = rd;
        in_a = a; in_b = b; in_imm = imm;
        #1;
        waits = 0;
        while (!in_ready) begin
            if (op == 3'd4 && !poison && waits > 0)
                chk(!in_ready, "R5 no accept while waiting", {31'd0, in_ready}, 32'd0);
            @(negedge clk); #1;
            waits++;
        end
        if (op == 3'd4 && !poison && !stall_on)
            chk(waits == 3, "R4 multiply accept delay", waits, 32'd3);
        chk(bypass_valid == e_byp, "R3 bypass_valid", {31'd0, bypass_valid}, {31'd0, e_byp});
        if (e_byp) begin
            chk(bypass_data == e.data, "R3 bypass_data", bypass_data, e.data);
            chk(bypass_rd == rd, "R3 bypass_rd", {27'd0, bypass_rd}, {27'd0, rd});
        end
        chk(redir_valid == e_redir, "R6 redir_valid", {31'd0, redir_valid}, {31'd0, e_redir});
        if (e_redir) chk(redir_target == imm, "R6 redir_target", redir_target, imm);
        if (poison) chk(!mem_req_valid && !bypass_valid && !redir_valid,
                        "R1 poisoned side effects", {29'd0, mem_req_valid, bypass_valid, redir_valid}, 32'd0);
        exp_q.push_back(e);
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (e_redir) m_epoch = ~m_epoch;
        chk(cur_epoch == m_epoch, "R6 cur_epoch", {31'd0, cur_epoch}, {31'd0, m_epoch});
    endtask

    // monitor: consumer handshake, hold check, scoreboard compare
    always @(negedge clk) begin
        cyc++;
        wb_ready = stall_on ? (cyc % 3 == 0) : 1'b1;
        #1;
        if (rst_n) begin
            if (mem_req_valid) mem_seen++;
            if (hold_pend)
                chk(wb_valid && wb_data == hold_data, "R8 held result", wb_data, hold_data);
            hold_pend = wb_valid && !wb_ready;
            hold_data = wb_data;
            if (wb_valid && wb_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected result", wb_data, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(wb_poison == e.poison, e.poison ? "R1 wb_poison" : "R2 wb_poison",
                        {31'd0, wb_poison}, {31'd0, e.poison});
                    chk(wb_op == e.op && wb_rd == e.rd && wb_wen == e.wen, "R8 order op/rd/wen",
                        {23'd0, wb_op, wb_rd, wb_wen}, {23'd0, e.op, e.rd, e.wen});
                    chk(wb_data == e.data,
                        e.poison ? "R1 data" : (e.op == 3'd4 ? "R4 product" :
                        (e.op == 3'd5 || e.op == 3'd6) ? "R7 mem data" : "R2 result"),
                        wb_data, e.data);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!cur_epoch && !wb_valid && !in_ready && !bypass_valid && !redir_valid && !mem_req_valid,
            "R9 reset state", {26'd0, cur_epoch, wb_valid, in_ready, bypass_valid, redir_valid, mem_req_valid}, 32'd0);

        send(3'd0, 1'b0, 5'd1, 32'h0000_1234, 32'h0000_0F0F, 32'd0);
        send(3'd1, 1'b0, 5'd2, 32'h0000_0005, 32'h0000_0009, 32'd0);
        send(3'd2, 1'b0, 5'd3, 32'hF0F0_AAAA, 32'h0FF0_FF00, 32'd0);
        send(3'd3, 1'b0, 5'd4, 32'hDEAD_BEEF, 32'hFFFF_0000, 32'd0);
        send(3'd4, 1'b0, 5'd5, 32'h1234_5678, 32'h9ABC_DEF0, 32'd0);
        send(3'd4, 1'b0, 5'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0);
        send(3'd0, 1'b0, 5'd7, 32'h0000_0001, 32'h0000_0002, 32'd0);
        send(3'd5, 1'b0, 5'd8, 32'h0000_1000, 32'd0, 32'h0000_0020);
        send(3'd6, 1'b0, 5'd9, 32'h0000_2000, 32'h5555_AAAA, 32'h0000_0004);
        send(3'd7, 1'b0, 5'd0, 32'd3, 32'd4, 32'h0000_0400);
        send(3'd7, 1'b0, 5'd0, 32'd7, 32'd7, 32'h0000_0800);
        // shadow of the taken branch: old epoch is poisoned
        send(3'd0, 1'b0, 5'd10, 32'd1, 32'd1, 32'd0);
        send(3'd5, 1'b0, 5'd11, 32'h100, 32'd0, 32'd8);
        send(3'd4, 1'b0, 5'd12, 32'd3, 32'd5, 32'd0);
        send(3'd7, 1'b0, 5'd0, 32'd9, 32'd9, 32'h0000_0C00);
        send(3'd6, 1'b0, 5'd13, 32'h300, 32'h77, 32'd0);
        send(3'd0, 1'b1, 5'd14, 32'd40, 32'd2, 32'd0);
        // stalled consumer
        stall_on = 1'b1;
        for (int i = 0; i < 6; i++) begin
            send(3'd0, 1'b1, 5'(16 + i), 32'(i * 17), 32'(i + 3), 32'd0);
            send(3'd4, 1'b1, 5'(24 + i), 32'(32'h0001_0003 * (i + 1)), 32'(32'h0000_FFFF + i), 32'd0);
        end
        send(3'd5, 1'b1, 5'd30, 32'h4000, 32'd0, 32'h10);
        stall_on = 1'b0;

        for (int t = 0; t < 200 && exp_q.size() != 0; t++) @(negedge clk);
        #2;
        chk(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 32'd0);
        chk(mem_seen == mem_exp, "R7 memory request count", mem_seen, mem_exp);
        report();
    end
endmodule